// File: doc/BRIEF.md
# Legacy Parallel Printer Port Register Controller

This block is the host side of a PC-compatible parallel printer port. A host reaches it through three byte-wide registers, selected by a two-bit offset and qualified by separate read and write strobes. On the connector side it drives eight data lines with a shared output enable and four open-collector control lines, and it senses five status lines. It also raises an interrupt request when the acknowledge line falls. Read data is combinational while the read strobe is high and is zero otherwise. The reset input is asynchronous active-low, and its release is expected to be synchronous to `clk`.

Each line has its own polarity. Some register bits read or drive the inverse of their pin. The data and control registers read back the levels actually on the pins, not the values last written. Because of this, a released control line can be pulled low by an outside device and sensed, and while the data drivers are tristated the data lines act as an input byte. The five status lines are asynchronous, so they pass through a synchronizer before they are read or used for edge detection.

Top module: `lpt_regs`

## Requirements
- R1: After reset `pd_out` is 0x00, `pd_oe` is 1, `ctl_drive_low` is 0000b (all four control lines released), `irq_oe` is 0 and `irq_out` is 0.
- R2: A write at offset 0 places the byte on `pd_out` from the next clock cycle. The byte holds until the next write at offset 0, whatever the direction setting.
- R3: A read at offset 0 returns `pd_in`, the levels on the data pins, in the same cycle.
- R4: A read at offset 1 returns the status lines `stat_pins` = {busy[4], ack[3], paper-out[2], select-in[1], error[0]}. They are laid out as bit 7 = NOT busy, bit 6 = ack, bit 5 = paper-out, bit 4 = select-in, bit 3 = error, and bits 2:0 = 0. A pin change becomes visible in a read issued after the second rising clock edge that follows it, and not before.
- R5: Writes at offset 1 or offset 3 change no output. A read at offset 3 returns 0x00, and `rdata` is 0x00 whenever `rd_en` is low.
- R6: A write at offset 2 sets `ctl_drive_low` to wdata[3:0] XOR 0100b from the next cycle. Bit 0 is strobe, bit 1 is auto-feed and bit 3 is select, and a 1 in any of these pulls its line low. Bit 2 is initialize, and a 0 there pulls its line low. Writing 0100b releases all four lines.
- R7: A read at offset 2 returns `ctl_pin_in` XOR 1011b in bits 3:0. Bits 5:4 return the last written bits 5:4, and bits 7:6 read 0 and are ignored on write.
- R8: Control bit 5 = 1 drives `pd_oe` low. Offset-0 writes still update the latch on `pd_out`, and offset-0 reads return the externally driven levels. When bit 5 is cleared, the latched byte appears on the pins.
- R9: Control bit 4 is the interrupt enable, and `irq_oe` follows it. While it is enabled, a falling edge on the ack line gives a one-cycle pulse on `irq_out`, high after the third rising edge that follows the pin change. A rising edge gives no pulse, and no pulse occurs while the enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pd_out | output | 8 | Data latch value toward the data pins |
| pd_oe | output | 1 | Data pin driver enable |
| pd_in | input | 8 | Levels sensed on the data pins |
| ctl_drive_low | output | 4 | 1 pulls the matching control line low, 0 releases it |
| ctl_pin_in | input | 4 | Levels sensed on the control lines |
| stat_pins | input | 5 | Status lines {busy, ack, paper-out, select-in, error} |
| irq_out | output | 1 | Interrupt request pulse |
| irq_oe | output | 1 | Interrupt line driver enable |

## Verification
The three kinds of result fall due at different times, and each check waits for its own time. Register writes reach `pd_out`, `pd_oe` and `ctl_drive_low` at the rising edge that samples the strobe, so those outputs are checked at the falling edge that follows it. Reads of data and control pins are combinational and are sampled one nanosecond after the strobe is raised on a falling edge. A status change is read back once after one edge, where the old value must still show, and again after two edges, where the new value must show. The interrupt is checked after the second, third and fourth edges that follow an ack fall, expecting 0, 1 and 0, and is watched over several cycles for rising edges and while disabled.

// File: rtl/lpt_pkg.sv
`timescale 1ns/1ps
package lpt_pkg;
  localparam int BYTE_W  = 8;
  localparam int CTL_W   = 4;
  localparam int STAT_W  = 5;
  localparam int OFS_W   = 2;

  localparam logic [OFS_W-1:0] OFS_DATA = 2'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 2'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 2'd2;

  // Lines whose register sense is opposite to the pin level
  localparam logic [CTL_W-1:0] CTL_INV     = 4'b1011;
  // Register value that lets every open-collector line float high
  localparam logic [CTL_W-1:0] CTL_RELEASE = 4'b0100;

  localparam int ST_BUSY  = 4;
  localparam int ST_ACK   = 3;
  localparam int ST_PAPER = 2;
  localparam int ST_SEL   = 1;
  localparam int ST_ERR   = 0;

  typedef struct packed {
    logic             bidir;  // 1: data drivers off
    logic             ien;    // interrupt enable
    logic [CTL_W-1:0] lines;  // printer control lines, register sense
  } ctl_t;

  localparam int CTL_REG_W = $bits(ctl_t);
endpackage

// File: rtl/lpt_sync.sv
`timescale 1ns/1ps
module lpt_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stg
      logic [W-1:0] r;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '0;
          else        r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '0;
          else        r <= g_stg[g-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/lpt_latches.sv
`timescale 1ns/1ps
module lpt_latches
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wbyte,
  input  ctl_t              wctl,
  output logic [BYTE_W-1:0] data_q,
  output ctl_t              ctrl_q
);
  logic [BYTE_W-1:0] data_d;
  ctl_t              ctrl_d;

  always_comb begin
    data_d = data_q;
    ctrl_d = ctrl_q;
    if (wr_data) data_d = wbyte;
    if (wr_ctrl) ctrl_d = wctl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q       <= '0;
      ctrl_q.bidir <= 1'b0;
      ctrl_q.ien   <= 1'b0;
      ctrl_q.lines <= CTL_RELEASE;
    end else begin
      data_q <= data_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/lpt_ack_irq.sv
`timescale 1ns/1ps
module lpt_ack_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic ien,
  output logic irq_pulse
);
  logic ack_d;
  logic irq_q, irq_d;

  always_comb begin
    irq_d = ien & ack_d & ~ack_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ack_d <= ack_s;
      irq_q <= irq_d;
    end
  end

  assign irq_pulse = irq_q & ien;
endmodule

// File: rtl/lpt_regs.sv
`timescale 1ns/1ps
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] pd_out,
  output logic              pd_oe,
  input  logic [BYTE_W-1:0] pd_in,
  output logic [CTL_W-1:0]  ctl_drive_low,
  input  logic [CTL_W-1:0]  ctl_pin_in,
  input  logic [STAT_W-1:0] stat_pins,
  output logic              irq_out,
  output logic              irq_oe
);
  logic [STAT_W-1:0] stat_s;
  logic [BYTE_W-1:0] data_q;
  ctl_t              ctrl_q;
  logic              wr_data, wr_ctrl;

  assign wr_data = wr_en && (addr == OFS_DATA);
  assign wr_ctrl = wr_en && (addr == OFS_CTRL);

  lpt_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (stat_pins),
    .q     (stat_s)
  );

  lpt_latches i_latches (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_data),
    .wr_ctrl (wr_ctrl),
    .wbyte   (wdata),
    .wctl    (ctl_t'(wdata[CTL_REG_W-1:0])),
    .data_q  (data_q),
    .ctrl_q  (ctrl_q)
  );

  lpt_ack_irq i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_s     (stat_s[ST_ACK]),
    .ien       (ctrl_q.ien),
    .irq_pulse (irq_out)
  );

  assign pd_out        = data_q;
  assign pd_oe         = ~ctrl_q.bidir;
  assign ctl_drive_low = ctrl_q.lines ^ CTL_RELEASE;
  assign irq_oe        = ctrl_q.ien;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_DATA: rdata = pd_in;
        OFS_STAT: rdata = {~stat_s[ST_BUSY], stat_s[ST_ACK], stat_s[ST_PAPER],
                           stat_s[ST_SEL], stat_s[ST_ERR], 3'b000};
        OFS_CTRL: rdata = {2'b00, ctrl_q.bidir, ctrl_q.ien, ctl_pin_in ^ CTL_INV};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lpt_regs_chk.sv
`timescale 1ns/1ps
module lpt_regs_chk
  import lpt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OFS_W-1:0]  addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic [BYTE_W-1:0] pd_out,
  input logic              pd_oe,
  input logic [BYTE_W-1:0] pd_in,
  input logic [CTL_W-1:0]  ctl_drive_low,
  input logic              irq_out,
  input logic              irq_oe
);
  assert_data_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DATA) |=> (pd_out == $past(wdata)));

  assert_data_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_DATA) |-> (rdata == pd_in));

  assert_stat_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_STAT) |-> (rdata[2:0] == 3'b000));

  assert_ignored_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_STAT || addr == 2'd3)) |=>
      ($stable(pd_out) && $stable(pd_oe) && $stable(ctl_drive_low) && $stable(irq_oe)));

  assert_ctl_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CTRL) |=> (ctl_drive_low == ($past(wdata[3:0]) ^ 4'b0100)));

  assert_ctl_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_CTRL) |-> (rdata[7:6] == 2'b00));

  assert_bidir_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CTRL) |=> (pd_oe == !$past(wdata[5])));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |=> !irq_out);

  assert_irq_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_oe);
endmodule

bind lpt_regs lpt_regs_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr          (addr),
  .wr_en         (wr_en),
  .rd_en         (rd_en),
  .wdata         (wdata),
  .rdata         (rdata),
  .pd_out        (pd_out),
  .pd_oe         (pd_oe),
  .pd_in         (pd_in),
  .ctl_drive_low (ctl_drive_low),
  .irq_out       (irq_out),
  .irq_oe        (irq_oe)
);

// File: tb/test_lpt_regs.sv
`timescale 1ns/1ps
module test_lpt_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pd_out, pd_in;
  logic       pd_oe, irq_out, irq_oe;
  logic [3:0] ctl_drive_low, ctl_pin_in;
  logic [4:0] stat_pins = 5'b01000;
  logic [7:0] ext_data = 8'h00;
  logic [3:0] ext_pull = 4'b0000;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // connector model: driven data or outside byte; open-collector lines with outside pull-downs
  assign pd_in      = pd_oe ? pd_out : ext_data;
  assign ctl_pin_in = ~ctl_drive_low & ~ext_pull;

  lpt_regs i_lpt_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .ctl_drive_low(ctl_drive_low), .ctl_pin_in(ctl_pin_in), .stat_pins(stat_pins),
    .irq_out(irq_out), .irq_oe(irq_oe)
  );

  // {control write, outside pull-downs, expected control read}
  localparam logic [19:0] CTL_VEC [7] = '{
    {8'h00, 4'b0000, 8'h00},
    {8'h0F, 4'b0000, 8'h0F},
    {8'h35, 4'b0000, 8'h35},
    {8'h04, 4'b1111, 8'h0B},
    {8'h04, 4'b0101, 8'h01},
    {8'hC4, 4'b0000, 8'h04},
    {8'h1A, 4'b0000, 8'h1A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pd_out", pd_out, 8'h00);
    check("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
    check("R1 ctl_drive_low", {4'd0, ctl_drive_low}, 8'h00);
    check("R1 irq_oe", {7'd0, irq_oe}, 8'h00);
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 idle rdata", rdata, 8'h00);

    // table walk over control writes and readback
    foreach (CTL_VEC[i]) begin
      @(negedge clk);
      ext_pull = CTL_VEC[i][11:8];
      wr(2'd2, CTL_VEC[i][19:12]);
      check("R6 drive", {4'd0, ctl_drive_low}, {4'd0, CTL_VEC[i][15:12] ^ 4'b0100});
      rd(2'd2, v);
      check("R7 ctl read", v, CTL_VEC[i][7:0]);
    end
    ext_pull = 4'b0000;
    wr(2'd2, 8'h04);

    // R2 R3 data write and pin readback
    wr(2'd0, 8'hA5);
    check("R2 latch A5", pd_out, 8'hA5);
    rd(2'd0, v);
    check("R3 read A5", v, 8'hA5);
    wr(2'd0, 8'h3C);
    check("R2 latch 3C", pd_out, 8'h3C);
    repeat (3) @(negedge clk);
    check("R2 hold 3C", pd_out, 8'h3C);

    // R5 ignored writes
    wr(2'd1, 8'hFF);
    check("R5 stat write pd_out", pd_out, 8'h3C);
    check("R5 stat write drive", {4'd0, ctl_drive_low}, 8'h00);
    wr(2'd3, 8'hFF);
    check("R5 ofs3 write pd_out", pd_out, 8'h3C);
    check("R5 ofs3 write oe", {6'd0, irq_oe, pd_oe}, 8'h01);
    rd(2'd3, v);
    check("R5 ofs3 read", v, 8'h00);

    // R4 status layout and latency
    @(negedge clk);
    stat_pins = 5'b10110;
    @(posedge clk); @(posedge clk);
    rd(2'd1, v);
    check("R4 status 10110", v, 8'h30);
    @(negedge clk);
    stat_pins = 5'b01001;
    @(posedge clk);
    rd(2'd1, v);
    check("R4 status not yet", v, 8'h30);
    @(posedge clk);
    rd(2'd1, v);
    check("R4 status 01001", v, 8'hC8);

    // R8 bidirectional mode
    wr(2'd2, 8'h24);
    check("R8 oe off", {7'd0, pd_oe}, 8'h00);
    ext_data = 8'h5A;
    rd(2'd0, v);
    check("R8 read outside", v, 8'h5A);
    wr(2'd0, 8'h77);
    check("R8 latch while off", pd_out, 8'h77);
    rd(2'd0, v);
    check("R8 still outside", v, 8'h5A);
    wr(2'd2, 8'h04);
    rd(2'd0, v);
    check("R8 latch returns", v, 8'h77);

    // R9 interrupt on ack fall
    wr(2'd2, 8'h14);
    check("R9 irq_oe on", {7'd0, irq_oe}, 8'h01);
    stat_pins[3] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 irq before", {7'd0, irq_out}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R9 irq pulse", {7'd0, irq_out}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R9 irq single", {7'd0, irq_out}, 8'h00);
    stat_pins[3] = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (irq_out) seen = 1'b1;
    end
    check("R9 no irq on rise", {7'd0, seen}, 8'h00);
    wr(2'd2, 8'h04);
    check("R9 irq_oe off", {7'd0, irq_oe}, 8'h00);
    stat_pins[3] = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (irq_out) seen = 1'b1;
    end
    check("R9 no irq disabled", {7'd0, seen}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule